// File: doc/BRIEF.md
# VCO Coarse Band Selection Engine

This engine picks the coarse tuning word of a VCO before the fine loop is closed. When started, it drives each 4-bit coarse word in turn, from 0 up to 15, onto its output. It lets the oscillator settle, then counts rising edges of a divided VCO clock over a fixed window of reference cycles. For each word it compares the edge count with a target count that stands for the wanted frequency. It keeps the word whose count lies closest to the target.

When the last word has been measured, the engine drives the winning word on its output and raises a completion flag. Both stay put until a new start. The settling length, the window length and the target are inputs, so firmware or a sequencer can set them per band. The divided VCO clock is asynchronous. It passes through a two-stage synchroniser into the reference domain before its rising edges are detected and counted.

Top module: `coarse_band_cal`

## Requirements
- R1: While `rstN` is low, `dacCode` is 0 and `done` is 0.
- R2: A high `start` sampled while the engine is idle or finished begins a sweep. On the next cycle `dacCode` is 0 and `done` is 0.
- R3: Each trial word is held for `settleLen`+1 settling cycles, then `windowLen` counting cycles, then one evaluation cycle. After that the word increases by one. During a sweep `dacCode` only ever stays the same or goes up by one.
- R4: A rising edge of `vcoDiv` that is present at a reference edge t is counted if cycle t+2 falls inside the counting window. This is the two-flop synchroniser plus edge-detect latency.
- R5: The selected word is the one with the smallest absolute difference |count − `targetCount`|.
- R6: When two words have equal difference, the lower word wins.
- R7: `done` rises in the same cycle that `dacCode` takes the selected word, which happens right after word 15 is evaluated.
- R8: While `done` is high and `start` is low, `dacCode` and `done` do not change.
- R9: A high `start` during a sweep has no effect on the sweep's sequence or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (idle or finished only) |
| vcoDiv | input | 1 | Divided VCO clock, asynchronous |
| settleLen | input | TIME_W | Settling cycles minus one per word |
| windowLen | input | TIME_W | Counting window in reference cycles (nonzero) |
| targetCount | input | CNT_W | Edge count that matches the wanted frequency |
| dacCode | output | CODE_W | Coarse DAC word: trial word, then the selected word |
| done | output | 1 | Selection finished, result valid |

## Verification
`dacCode` and `done` change one clock after the edge that samples `start`, the end of a window, or the end of settling. A rising edge of `vcoDiv` affects the count three edges after it is driven, because of the two synchroniser stages and the edge-detect register. The bench's reference model holds its own three-deep history of sampled `vcoDiv` values to reproduce that delay. It advances its phase counters on each rising edge and compares both outputs at every falling edge, halfway between updates. Final selections are also checked against words known in advance: the lowest and highest bands, and the all-tie case.

// File: rtl/band_cal_pkg.sv
package band_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_COUNT,
    ST_EVAL,
    ST_DONE
  } calState_t;

  typedef struct packed {
    logic firstCode;
    logic clrTimer;
    logic incTimer;
    logic clrCount;
    logic countEn;
    logic evalEn;
    logic stepCode;
    logic loadBest;
  } calStrobe_t;

endpackage

// File: rtl/band_cal_dp.sv
module band_cal_dp
  import band_cal_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobe,
  input  logic              vcoDiv,
  input  logic [TIME_W-1:0] settleLen,
  input  logic [TIME_W-1:0] windowLen,
  input  logic [CNT_W-1:0]  targetCount,
  output logic              settleEnd,
  output logic              windowEnd,
  output logic              lastCode,
  output logic [CODE_W-1:0] dacCode
);

  localparam int HIST_W = SYNC_STAGES + 1;
  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  logic [HIST_W-1:0] syncHist;
  logic              edgePulse;
  logic [TIME_W-1:0] timer;
  logic [CNT_W-1:0]  edgeCnt;
  logic [CODE_W-1:0] trialCode;
  logic [CODE_W-1:0] bestCode;
  logic [CNT_W-1:0]  bestDiff;
  logic [CNT_W-1:0]  curDiff;
  logic              better;
  logic [CODE_W-1:0] finalBest;

  // synchroniser chain plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncHist <= '0;
    else       syncHist <= {syncHist[HIST_W-2:0], vcoDiv};
  end

  assign edgePulse = syncHist[HIST_W-2] & ~syncHist[HIST_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (strobe.clrTimer)  timer <= '0;
    else if (strobe.incTimer)  timer <= timer + 1'b1;
  end

  assign settleEnd = (timer == settleLen);
  assign windowEnd = (timer == TIME_W'(windowLen - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            edgeCnt <= '0;
    else if (strobe.clrCount)             edgeCnt <= '0;
    else if (strobe.countEn && edgePulse) edgeCnt <= edgeCnt + 1'b1;
  end

  assign curDiff   = (edgeCnt >= targetCount) ? (edgeCnt - targetCount)
                                              : (targetCount - edgeCnt);
  assign better    = (trialCode == '0) || (curDiff < bestDiff);
  assign finalBest = better ? trialCode : bestCode;
  assign lastCode  = (trialCode == TOP_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestCode <= '0;
      bestDiff <= '0;
    end else if (strobe.evalEn && better) begin
      bestCode <= trialCode;
      bestDiff <= curDiff;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode <= '0;
      dacCode   <= '0;
    end else if (strobe.firstCode) begin
      trialCode <= '0;
      dacCode   <= '0;
    end else if (strobe.stepCode) begin
      trialCode <= trialCode + 1'b1;
      dacCode   <= trialCode + 1'b1;
    end else if (strobe.loadBest) begin
      dacCode   <= finalBest;
    end
  end

endmodule

// File: rtl/band_cal_ctrl.sv
module band_cal_ctrl
  import band_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       settleEnd,
  input  logic       windowEnd,
  input  logic       lastCode,
  output calStrobe_t strobe,
  output logic       done
);

  calState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.firstCode = 1'b1;
          strobe.clrTimer  = 1'b1;
          stateNext        = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settleEnd) begin
          strobe.clrTimer = 1'b1;
          strobe.clrCount = 1'b1;
          stateNext       = ST_COUNT;
        end else begin
          strobe.incTimer = 1'b1;
        end
      end
      ST_COUNT: begin
        strobe.countEn = 1'b1;
        if (windowEnd) stateNext = ST_EVAL;
        else           strobe.incTimer = 1'b1;
      end
      ST_EVAL: begin
        strobe.evalEn = 1'b1;
        if (lastCode) begin
          strobe.loadBest = 1'b1;
          stateNext       = ST_DONE;
        end else begin
          strobe.stepCode = 1'b1;
          strobe.clrTimer = 1'b1;
          stateNext       = ST_SETTLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/coarse_band_cal.sv
module coarse_band_cal
  import band_cal_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              vcoDiv,
  input  logic [TIME_W-1:0] settleLen,
  input  logic [TIME_W-1:0] windowLen,
  input  logic [CNT_W-1:0]  targetCount,
  output logic [CODE_W-1:0] dacCode,
  output logic              done
);

  calStrobe_t strobe;
  logic       settleEnd;
  logic       windowEnd;
  logic       lastCode;

  band_cal_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .settleEnd (settleEnd),
    .windowEnd (windowEnd),
    .lastCode  (lastCode),
    .strobe    (strobe),
    .done      (done)
  );

  band_cal_dp #(
    .CODE_W (CODE_W),
    .TIME_W (TIME_W),
    .CNT_W  (CNT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .vcoDiv      (vcoDiv),
    .settleLen   (settleLen),
    .windowLen   (windowLen),
    .targetCount (targetCount),
    .settleEnd   (settleEnd),
    .windowEnd   (windowEnd),
    .lastCode    (lastCode),
    .dacCode     (dacCode)
  );

endmodule

// File: rtl/band_cal_chk.sv
module band_cal_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CODE_W-1:0] dacCode,
  input logic              done
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (dacCode == '0 && !done));

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (!done && dacCode == '0));

  // R3
  code_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> (done || dacCode == $past(dacCode) ||
               dacCode == CODE_W'($past(dacCode) + 1'b1)));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(dacCode) == {CODE_W{1'b1}}));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(dacCode)));

endmodule

bind coarse_band_cal band_cal_chk #(.CODE_W(CODE_W)) u_band_cal_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .dacCode (dacCode),
  .done    (done)
);

// File: tb/test_coarse_band_cal.sv
module test_coarse_band_cal;

  localparam int CODE_W = 4;
  localparam int TIME_W = 16;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              vcoDiv = 1'b0;
  logic [TIME_W-1:0] settleLen = '0;
  logic [TIME_W-1:0] windowLen = 16'd10;
  logic [CNT_W-1:0]  targetCount = '0;
  logic [CODE_W-1:0] dacCode;
  logic              done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit vcoRun = 1'b0;
  int halfCnt = 0;

  always #4 clk = ~clk;

  coarse_band_cal #(.CODE_W(CODE_W), .TIME_W(TIME_W), .CNT_W(CNT_W)) i_coarse_band_cal (
    .clk(clk), .rstN(rstN), .start(start), .vcoDiv(vcoDiv),
    .settleLen(settleLen), .windowLen(windowLen), .targetCount(targetCount),
    .dacCode(dacCode), .done(done)
  );

  // VCO stand-in: half period in reference cycles falls as the word rises
  always @(negedge clk) begin
    if (vcoRun) begin
      halfCnt++;
      if (halfCnt >= 20 - int'(dacCode)) begin
        halfCnt = 0;
        vcoDiv <= ~vcoDiv;
      end
    end
  end

  // behavioural reference model
  int mPhase;   // 0 idle, 1 settle, 2 count, 3 eval, 4 finished
  int mTimer, mCnt, mCode, mBest, mBestDiff, mDac, mDone;
  bit mHist[$];

  task automatic modelReset();
    mPhase = 0; mTimer = 0; mCnt = 0; mCode = 0; mBest = 0;
    mBestDiff = 0; mDac = 0; mDone = 0;
    mHist = '{1'b0, 1'b0, 1'b0};
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      bit pulse;
      int d;
      pulse = mHist[1] && !mHist[0];
      void'(mHist.pop_front());
      mHist.push_back(vcoDiv);
      case (mPhase)
        0, 4: if (start) begin
          mPhase = 1; mTimer = 0; mCode = 0; mDac = 0; mDone = 0;
        end
        1: if (mTimer == int'(settleLen)) begin
          mPhase = 2; mTimer = 0; mCnt = 0;
        end else mTimer++;
        2: begin
          if (pulse) mCnt++;
          if (mTimer == int'(windowLen) - 1) mPhase = 3;
          else mTimer++;
        end
        default: begin
          d = (mCnt >= int'(targetCount)) ? mCnt - int'(targetCount)
                                          : int'(targetCount) - mCnt;
          if (mCode == 0 || d < mBestDiff) begin
            mBest = mCode; mBestDiff = d;
          end
          if (mCode == 15) begin
            mPhase = 4; mDac = mBest; mDone = 1;
          end else begin
            mCode++; mDac = mCode; mTimer = 0; mPhase = 1;
          end
        end
      endcase
    end
  end

  // compare on every clock, half a period after the update edge
  always @(negedge clk) begin
    cycles++;
    checks++;
    if (int'(dacCode) != mDac) begin
      fails++;
      $display("FAIL %s dacCode actual %0d expected %0d at cycle %0d",
               mDone ? "R5" : "R3", dacCode, mDac, cycles);
    end
    checks++;
    if (int'(done) != mDone) begin
      fails++;
      $display("FAIL R7 done actual %0d expected %0d at cycle %0d", done, mDone, cycles);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runSweep(input int st, input int win, input int tgt,
                          input bit vcoOn, input bit midStart);
    @(negedge clk);
    settleLen = TIME_W'(st); windowLen = TIME_W'(win); targetCount = CNT_W'(tgt);
    vcoRun = vcoOn; vcoDiv = 1'b0; halfCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 code after start", int'(dacCode), 0);
    check("R2 done after start", int'(done), 0);
    if (midStart) begin
      repeat (3 * (st + win)) @(negedge clk);
      start = 1'b1;                       // R9: must be ignored
      repeat (2) @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (12) @(negedge clk);
    check("R8 done held", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 code in reset", int'(dacCode), 0);
    check("R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle code", int'(dacCode), 0);

    // R4 R5: target between bands, model-derived counts
    runSweep(5, 200, 10, 1'b1, 1'b0);
    check("R4 R5 mid target", int'(dacCode), mBest);

    // R5: zero target picks the slowest band, zero settle
    runSweep(0, 120, 0, 1'b1, 1'b0);
    check("R5 low target", int'(dacCode), 0);

    // R5: huge target picks the fastest band
    runSweep(2, 120, 60000, 1'b1, 1'b0);
    check("R5 high target", int'(dacCode), 15);

    // R6: no edges, every word ties
    runSweep(1, 50, 3, 1'b0, 1'b0);
    check("R6 tie to lower", int'(dacCode), 0);

    // R9: start during sweep ignored
    runSweep(3, 100, 7, 1'b1, 1'b1);
    check("R9 result", int'(dacCode), mBest);
    check("R9 done", int'(done), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual %0d expected below 150000 cycles", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule